// File: doc/BRIEF.md
# RTC Interrupt and Square-Wave Generator

This block takes a 32.768 kHz tick and raises three kinds of interrupt events. A periodic event comes at a programmable rate. An update-ended event follows each clock update cycle. An alarm event fires when the current time matches the programmed alarm time. Each event sets its own status flag, whether or not that source is enabled. An enable mask selects which flags drive the active-low interrupt request pin. Reading the flag register returns the flags and then clears them. The tap of the tick divider that paces the periodic event also drives a square-wave output, which has its own gate.

The timekeeping counters sit outside this block and supply three things: the current time fields, the alarm fields and a one-cycle `update_done` pulse after each update. An alarm field whose two top bits are both 1 matches any value. With all three fields set that way the alarm fires every second. With only the hour field set that way it fires once an hour, and with no field set that way it fires once a day.

The request logic is a two-state machine. `IRQ_IDLE` moves to `IRQ_ACTIVE` when the next flag value, masked by the enables, is non-zero. `IRQ_ACTIVE` moves back to `IRQ_IDLE` when that masked value becomes zero, for example after a read or after the enables are cleared. In all other cases each state holds.

Top module: `rtc_irq_sqw`

## Requirements
- R1: After reset, `flag_rdata` is 0, `irq_n` is 1 and `sqw` is 0.
- R2: For `rate_sel` from 3 to 15, the periodic flag (`flag_rdata[2]`) is set at the clock after tick number k·2^(rate_sel−1), counted from reset. Rate 3 gives 4 ticks and rate 15 gives 16384 ticks.
- R3: `rate_sel` 1 gives a period of 2^7 ticks and `rate_sel` 2 gives 2^8 ticks. `rate_sel` 0 never sets the periodic flag and holds `sqw` at 0.
- R4: With period 2^e, `sqw` equals bit e−1 of the tick count since reset when `sqw_en` is 1, and it is 0 when `sqw_en` is 0.
- R5: A cycle with `update_done` high sets the update flag (`flag_rdata[0]`) at the next clock.
- R6: A cycle with `update_done` high sets the alarm flag (`flag_rdata[1]`) if every 8-bit field of `alarm_time` either equals the matching field of `cur_time` or has bits [7:6] = 2'b11.
- R7: Flags are set whatever the enable bits are. `irq_en` bit 2 enables the periodic flag, bit 1 the alarm flag and bit 0 the update flag. `flag_rdata[3]` is updated at each clock to the OR of the next flags ANDed with `irq_en` of that cycle.
- R8: A cycle with `flag_rd` high returns the flags held before the clock and then clears them. An event that arrives in the same cycle as the read stays set.
- R9: `irq_n` is 0 exactly when `flag_rdata[3]` is 1. It models an open-drain pin: 0 means the pin is pulled low and 1 means it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_32k | input | 1 | One-cycle pulse at 32.768 kHz |
| rate_sel | input | 4 | Shared rate for the periodic flag and the square wave |
| sqw_en | input | 1 | Square-wave output gate |
| irq_en | input | 3 | Enables: [2] periodic, [1] alarm, [0] update |
| update_done | input | 1 | Pulse at the end of each update cycle |
| cur_time | input | 24 | Current hour, minute and second fields |
| alarm_time | input | 24 | Alarm fields; a field with top bits 11 is don't-care |
| flag_rd | input | 1 | Read strobe for the flag register |
| flag_rdata | output | 4 | {IRQF, PF, AF, UF} |
| irq_n | output | 1 | Interrupt request, active low, open-drain model |
| sqw | output | 1 | Square-wave output |

## Verification
A flag read can fall in the same cycle as a new event: a periodic tick, an update pulse or an alarm match. The directed part of the bench sets the update flag and then pulses `flag_rd` and `update_done` together. It expects the old value in the read data and the update flag still set afterwards. The random part fires reads, ticks and updates independently, so they overlap often. A bench model compares the flags, `irq_n` and `sqw` in every cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    typedef enum logic {IRQ_IDLE, IRQ_ACTIVE} irq_state_t;
    localparam int FLAG_UF = 0;
    localparam int FLAG_AF = 1;
    localparam int FLAG_PF = 2;
    localparam int NUM_SRC = 3;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
    parameter int RATE_W    = 4,
    parameter int ALIAS_ONE = 7,
    parameter int ALIAS_TWO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    output logic              per_pulse,
    output logic              sqw
);
    localparam int MAX_EXP = (1 << RATE_W) - 2;

    logic [MAX_EXP-1:0] cnt_q;
    logic [MAX_EXP-1:0] mask;
    logic               rate_on;
    logic               tap_bit;
    int unsigned        exp_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Map the rate code onto a power-of-two exponent in ticks.
    always_comb begin
        rate_on = 1'b1;
        unique case (rate_sel)
            '0:                      begin exp_i = 0; rate_on = 1'b0; end
            RATE_W'(1):              exp_i = ALIAS_ONE;
            RATE_W'(2):              exp_i = ALIAS_TWO;
            default:                 exp_i = int'(rate_sel) - 1;
        endcase
    end

    always_comb begin
        tap_bit = 1'b0;
        for (int i = 0; i < MAX_EXP; i++) begin
            mask[i] = (i < exp_i);
            if (i + 1 == exp_i) tap_bit = cnt_q[i];
        end
    end

    assign per_pulse = tick && rate_on && ((cnt_q & mask) == mask);
    assign sqw       = sqw_en && rate_on && tap_bit;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 3
) (
    input  logic [FIELD_W*NUM_FIELDS-1:0] cur_time,
    input  logic [FIELD_W*NUM_FIELDS-1:0] alarm_time,
    output logic                          match
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] cur_f;
        logic [FIELD_W-1:0] alm_f;
        logic               any_val;
        assign cur_f   = cur_time[f*FIELD_W +: FIELD_W];
        assign alm_f   = alarm_time[f*FIELD_W +: FIELD_W];
        assign any_val = &alm_f[FIELD_W-1 -: 2];
        assign hit[f]  = any_val || (alm_f == cur_f);
    end

    assign match = &hit;
endmodule

// File: rtl/rtc_irq_sqw.sv
module rtc_irq_sqw
    import rtc_irq_pkg::*;
#(
    parameter int RATE_W     = 4,
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 3,
    localparam int TIME_W    = FIELD_W * NUM_FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic              update_done,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [TIME_W-1:0] alarm_time,
    input  logic              flag_rd,
    output logic [NUM_SRC:0]  flag_rdata,
    output logic              irq_n,
    output logic              sqw
);
    irq_state_t         state_q, state_n;
    logic [NUM_SRC-1:0] flag_q, flag_n, event_v;
    logic               per_pulse;
    logic               alarm_hit;
    logic               pending;

    rtc_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .rate_sel  (rate_sel),
        .sqw_en    (sqw_en),
        .per_pulse (per_pulse),
        .sqw       (sqw)
    );

    rtc_alarm_match #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_alarm (
        .cur_time   (cur_time),
        .alarm_time (alarm_time),
        .match      (alarm_hit)
    );

    always_comb begin
        event_v          = '0;
        event_v[FLAG_PF] = per_pulse;
        event_v[FLAG_AF] = update_done && alarm_hit;
        event_v[FLAG_UF] = update_done;
        flag_n           = (flag_rd ? '0 : flag_q) | event_v;
        pending          = |(flag_n & irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_n;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_n = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending) state_n = IRQ_IDLE;
            default:    state_n = IRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_n      = (state_q != IRQ_ACTIVE);
        flag_rdata = {state_q == IRQ_ACTIVE, flag_q};
    end
endmodule

// File: rtl/rtc_irq_sqw_chk.sv
module rtc_irq_sqw_chk #(
    parameter int RATE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_32k,
    input logic              update_done,
    input logic              flag_rd,
    input logic              sqw_en,
    input logic [RATE_W-1:0] rate_sel,
    input logic [3:0]        flag_rdata,
    input logic              irq_n,
    input logic              sqw
);
    p_uf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |=> flag_rdata[0]);

    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !update_done && !tick_32k) |=> (flag_rdata[2:0] == 3'b000));

    p_pf_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rdata[2]) |-> $past(tick_32k));

    p_sqw_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |-> !sqw);

    p_rate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> !sqw);

    p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag_rdata[2:0] != 3'b000));
endmodule

bind rtc_irq_sqw rtc_irq_sqw_chk #(.RATE_W(RATE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_32k    (tick_32k),
    .update_done (update_done),
    .flag_rd     (flag_rd),
    .sqw_en      (sqw_en),
    .rate_sel    (rate_sel),
    .flag_rdata  (flag_rdata),
    .irq_n       (irq_n),
    .sqw         (sqw)
);

// File: tb/rtc_irq_sqw_tb.sv
`timescale 1ns/1ps
module rtc_irq_sqw_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic [3:0]  rate_sel = '0;
    logic        sqw_en = 1'b0;
    logic [2:0]  irq_en = '0;
    logic        update_done = 1'b0;
    logic [23:0] cur_time = '0;
    logic [23:0] alarm_time = '0;
    logic        flag_rd = 1'b0;
    logic [3:0]  flag_rdata;
    logic        irq_n;
    logic        sqw;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int unsigned m_cnt = 0;
    logic [2:0]  m_fl = '0;
    logic        m_irqf = 1'b0;

    always #10 clk = ~clk;

    rtc_irq_sqw u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .sqw_en(sqw_en), .irq_en(irq_en), .update_done(update_done),
        .cur_time(cur_time), .alarm_time(alarm_time), .flag_rd(flag_rd),
        .flag_rdata(flag_rdata), .irq_n(irq_n), .sqw(sqw)
    );

    function automatic int exp_of(input logic [3:0] r);
        if (r == 0) return 0;
        if (r == 1) return 7;
        if (r == 2) return 8;
        return int'(r) - 1;
    endfunction

    function automatic bit alarm_ok(input logic [23:0] c, input logic [23:0] a);
        for (int f = 0; f < 3; f++)
            if (!(a[f*8+6 +: 2] == 2'b11 || a[f*8 +: 8] == c[f*8 +: 8])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive, compare against the model, advance the model.
    task automatic step(input bit tk, input bit up, input bit rd);
        int  e;
        bit  es, pev;
        logic [2:0] ev, nf;
        @(negedge clk);
        tick_32k = tk; update_done = up; flag_rd = rd;
        #1;
        e  = exp_of(rate_sel);
        es = (e != 0) && sqw_en && (((m_cnt >> (e - 1)) & 1) == 1);
        check(sqw == es, "R4", sqw, es);
        check(irq_n == !m_irqf, "R9", irq_n, !m_irqf);
        check(flag_rdata[3] == m_irqf, "R7", flag_rdata[3], m_irqf);
        check(flag_rdata[2] == m_fl[2], "R2", flag_rdata[2], m_fl[2]);
        check(flag_rdata[1] == m_fl[1], "R6", flag_rdata[1], m_fl[1]);
        check(flag_rdata[0] == m_fl[0], "R5", flag_rdata[0], m_fl[0]);
        pev = tk && (e != 0) && ((m_cnt % (1 << e)) == (1 << e) - 1);
        ev  = {pev, up && alarm_ok(cur_time, alarm_time), up};
        nf  = (rd ? 3'b000 : m_fl) | ev;
        m_irqf = |(nf & irq_en);
        m_fl   = nf;
        if (tk) m_cnt = (m_cnt + 1) % (1 << 14);
        @(posedge clk);
        #1;
        tick_32k = 1'b0; update_done = 1'b0; flag_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check(flag_rdata == 4'h0, "R1", flag_rdata, 0);
        check(irq_n == 1'b1, "R1", irq_n, 1);
        check(sqw == 1'b0, "R1", sqw, 0);
        rst_n = 1'b1;

        // R2: rate 3 has a 4-tick period
        rate_sel = 4'd3; irq_en = 3'b100; sqw_en = 1'b1;
        ticks(3);
        check(flag_rdata[2] == 1'b0, "R2", flag_rdata[2], 0);
        ticks(1);
        check(flag_rdata[2] == 1'b1, "R2", flag_rdata[2], 1);
        check(irq_n == 1'b0, "R9", irq_n, 0);
        // R8: read clears
        step(1'b0, 1'b0, 1'b1);
        check(flag_rdata == 4'h0, "R8", flag_rdata, 0);
        check(irq_n == 1'b1, "R8", irq_n, 1);

        // R3: rate 1 aliases to 128 ticks (count is now 4)
        rate_sel = 4'd1;
        ticks(123);
        check(flag_rdata[2] == 1'b0, "R3", flag_rdata[2], 0);
        ticks(1);
        check(flag_rdata[2] == 1'b1, "R3", flag_rdata[2], 1);
        step(1'b0, 1'b0, 1'b1);
        // R3: rate 0 is silent
        rate_sel = 4'd0;
        ticks(40);
        check(flag_rdata[2] == 1'b0 && sqw == 1'b0, "R3", flag_rdata[2], 0);

        // R6 / R7: alarm with seconds don't-care, alarm not enabled
        irq_en = 3'b001;
        cur_time = 24'h123456; alarm_time = 24'h1234C0;
        step(1'b0, 1'b1, 1'b0);
        check(flag_rdata[1] == 1'b1, "R6", flag_rdata[1], 1);
        check(flag_rdata[0] == 1'b1, "R5", flag_rdata[0], 1);
        check(flag_rdata[3] == 1'b1, "R7", flag_rdata[3], 1);
        // R8: read coinciding with an update event
        step(1'b0, 1'b1, 1'b1);
        check(flag_rdata[0] == 1'b1, "R8", flag_rdata[0], 1);
        irq_en = 3'b010;
        alarm_time = 24'h123500;
        step(1'b0, 1'b1, 1'b1);
        check(flag_rdata[1] == 1'b0, "R6", flag_rdata[1], 0);
        check(irq_n == 1'b1, "R7", irq_n, 1);

        // Random phase
        for (int blk = 0; blk < 10; blk++) begin
            rate_sel = 4'($urandom % 7);
            sqw_en   = 1'($urandom % 2);
            irq_en   = 3'($urandom % 8);
            for (int f = 0; f < 3; f++)
                alarm_time[f*8 +: 8] = ($urandom % 3 == 0) ? (8'hC0 | 8'($urandom % 64))
                                                           : 8'($urandom % 4);
            for (int i = 0; i < 400; i++) begin
                bit up;
                up = ($urandom % 16 == 0);
                for (int f = 0; f < 3; f++)
                    cur_time[f*8 +: 8] = ($urandom % 2 == 0) ? alarm_time[f*8 +: 8]
                                                             : 8'($urandom % 4);
                step(1'($urandom % 2), up, ($urandom % 20 == 0));
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 20);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule